// File: doc/BRIEF.md
# Evenly Spread Step-Select Sequencer

This block produces a one-bit select stream that picks, on each clock, between two neighbouring oscillator settings. A high bit selects the faster setting (code k+1) and a low bit selects the slower one (code k). The caller programs a period length `n` in clocks and a count `m` of fast slots. The block then emits exactly `m` ones in every period of `n` clocks. Because the mean of the stream can sit at any fraction m/n, the average output frequency can be placed anywhere between the two settings. The clock-to-clock step never exceeds one setting.

The ones are not grouped into one contiguous pulse. A first-order phase accumulator adds `m` each clock and takes `n` away whenever the sum reaches `n`. The carry of that wrap is the select bit. A carry happens exactly where the accumulated phase passes the ideal phase, so the ones land as evenly as the period allows. A frame strobe marks the first slot of every period. New settings are taken only at period boundaries, and the accumulator is cleared at each boundary so that a reload always starts from a clean phase.

Control is a two-state machine:
- `ST_LOAD` is entered from reset. In this state the inputs are captured and the accumulator is cleared.
- The transition load-to-run is taken unconditionally on the next clock, and the block moves to `ST_RUN`.
- In `ST_RUN` the block generates slots.
- The transition run-to-run is taken on every clock. At the last slot of a period it also reloads the settings.

Top module: `pdm_spread`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `step_sel_o` and `frame_start_o` are 0.
- R2: Every period of `n` slots contains exactly `m` ones on `step_sel_o`, where `n` and `m` are the effective values.
- R3: Slot i of a period (i = 1..n, slot 1 marked by `frame_start_o`) carries floor(i*m/n) - floor((i-1)*m/n). A one appears exactly at each crossing of the ideal phase.
- R4: For m >= 1, the cyclic gaps between successive ones in a period differ by at most one clock.
- R5: m = 0 gives an all-zero stream, and m = n gives an all-one stream.
- R6: A `ones_cnt` larger than the effective period is clamped to that period.
- R7: A `period_len` of 0 is treated as a period of 1.
- R8: Changes on `period_len` or `ones_cnt` during a period do not affect that period. They take effect from the next period.
- R9: `frame_start_o` is 1 on the first slot of each period and 0 on every other slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_len | input | PERIOD_W | Period length n in clocks (0 means 1) |
| ones_cnt | input | PERIOD_W | Fast-slot count m per period (clamped to n) |
| step_sel_o | output | 1 | 1 selects setting k+1, 0 selects setting k |
| frame_start_o | output | 1 | High on the first slot of each period |

## Verification
The assertions assume that `rst` is high on the first clock edge. They also assume that the captured period and count follow the clamping rules, so that the accumulator stays below the period and closes to zero at the period end. The bench changes `period_len` and `ones_cnt` only on falling edges and holds reset across the first edges. Each scenario skips one full frame before it compares, so every compared period has settled settings. The exception is the mid-period change case, which is there to show that the running period is left unchanged.

// File: rtl/pdm_spread_pkg.sv
package pdm_spread_pkg;
    typedef enum logic [0:0] {
        ST_LOAD = 1'b0,
        ST_RUN  = 1'b1
    } pdm_state_e;
endpackage

// File: rtl/pdm_period_ctrl.sv
module pdm_period_ctrl
    import pdm_spread_pkg::*;
#(
    parameter int PERIOD_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PERIOD_W-1:0] period_len,
    input  logic [PERIOD_W-1:0] ones_cnt,
    output logic                run_o,
    output logic                last_o,
    output logic [PERIOD_W-1:0] n_o,
    output logic [PERIOD_W-1:0] m_o,
    output logic                frame_o
);
    localparam logic [PERIOD_W-1:0] ONE = PERIOD_W'(1);

    pdm_state_e          state_q, state_d;
    logic [PERIOD_W-1:0] n_q, m_q, pos_q;
    logic [PERIOD_W-1:0] n_eff, m_eff;
    logic                frame_q;
    logic                last;

    always_comb begin
        n_eff = (period_len == '0) ? ONE : period_len;
        m_eff = (ones_cnt > n_eff) ? n_eff : ones_cnt;
        last  = (pos_q == n_q - ONE);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD: state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_LOAD;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_LOAD;
        else     state_q <= state_d;
    end

    // per-state data and output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            n_q     <= ONE;
            m_q     <= '0;
            pos_q   <= '0;
            frame_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_LOAD: begin
                    n_q     <= n_eff;
                    m_q     <= m_eff;
                    pos_q   <= '0;
                    frame_q <= 1'b0;
                end
                ST_RUN: begin
                    frame_q <= (pos_q == '0);
                    if (last) begin
                        pos_q <= '0;
                        n_q   <= n_eff;
                        m_q   <= m_eff;
                    end else begin
                        pos_q <= pos_q + ONE;
                    end
                end
                default: begin
                    pos_q   <= '0;
                    frame_q <= 1'b0;
                end
            endcase
        end
    end

    assign run_o   = (state_q == ST_RUN);
    assign last_o  = last;
    assign n_o     = n_q;
    assign m_o     = m_q;
    assign frame_o = frame_q;

    a_r6_count_clamped: assert property (@(posedge clk) disable iff (rst)
        run_o |-> (m_q <= n_q));
    a_r7_period_nonzero: assert property (@(posedge clk) disable iff (rst)
        run_o |-> (n_q != '0));
    a_r8_hold_in_period: assert property (@(posedge clk) disable iff (rst)
        (run_o && !last) |=> ($stable(n_q) && $stable(m_q)));
    a_r9_frame_after_wrap: assert property (@(posedge clk) disable iff (rst)
        (run_o && last) |=> ##1 frame_q);
endmodule

// File: rtl/pdm_phase_acc.sv
module pdm_phase_acc #(
    parameter int PERIOD_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run_i,
    input  logic                last_i,
    input  logic [PERIOD_W-1:0] n_i,
    input  logic [PERIOD_W-1:0] m_i,
    output logic                sel_o
);
    localparam int SUM_W = PERIOD_W + 1;

    logic [PERIOD_W-1:0] acc_q;
    logic [SUM_W-1:0]    sum;
    logic                carry;
    logic                sel_q;

    always_comb begin
        sum   = {1'b0, acc_q} + {1'b0, m_i};
        carry = (sum >= {1'b0, n_i});
    end

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            acc_q <= '0;
            sel_q <= 1'b0;
        end else begin
            sel_q <= carry;
            if (last_i)     acc_q <= '0;
            else if (carry) acc_q <= PERIOD_W'(sum - {1'b0, n_i});
            else            acc_q <= PERIOD_W'(sum);
        end
    end

    assign sel_o = sel_q;

    a_r2_phase_below_period: assert property (@(posedge clk) disable iff (rst)
        run_i |-> (acc_q < n_i));
    a_r2_period_closes: assert property (@(posedge clk) disable iff (rst)
        (run_i && last_i) |-> (sum == '0 || sum == {1'b0, n_i}));
    a_r5_all_ones: assert property (@(posedge clk) disable iff (rst)
        (run_i && m_i == n_i) |=> sel_q);
    a_r5_all_zero: assert property (@(posedge clk) disable iff (rst)
        (run_i && m_i == '0) |=> !sel_q);
endmodule

// File: rtl/pdm_spread.sv
module pdm_spread #(
    parameter int PERIOD_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PERIOD_W-1:0] period_len,
    input  logic [PERIOD_W-1:0] ones_cnt,
    output logic                step_sel_o,
    output logic                frame_start_o
);
    logic                run, last;
    logic [PERIOD_W-1:0] n_cur, m_cur;

    pdm_period_ctrl #(.PERIOD_W(PERIOD_W)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .period_len (period_len),
        .ones_cnt   (ones_cnt),
        .run_o      (run),
        .last_o     (last),
        .n_o        (n_cur),
        .m_o        (m_cur),
        .frame_o    (frame_start_o)
    );

    pdm_phase_acc #(.PERIOD_W(PERIOD_W)) acc_i (
        .clk    (clk),
        .rst    (rst),
        .run_i  (run),
        .last_i (last),
        .n_i    (n_cur),
        .m_i    (m_cur),
        .sel_o  (step_sel_o)
    );

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> (!step_sel_o && !frame_start_o));
endmodule

// File: tb/pdm_spread_tb_top.sv
module pdm_spread_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] period_len = '0;
    logic [W-1:0] ones_cnt = '0;
    logic         step_sel_o, frame_start_o;
    int           n_checks = 0;
    int           n_fail = 0;
    bit           done = 1'b0;

    always #4 clk = ~clk;

    pdm_spread #(.PERIOD_W(W)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .period_len    (period_len),
        .ones_cnt      (ones_cnt),
        .step_sel_o    (step_sel_o),
        .frame_start_o (frame_start_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_frame();
        while (frame_start_o !== 1'b1) @(negedge clk);
    endtask

    // checks one whole period; call on the negedge showing slot 1
    task automatic check_period(input int ne, input int me, input string tag);
        int ones = 0;
        int first_pos = -1;
        int prev_pos = -1;
        int gmin = 1 << 20;
        int gmax = -1;
        for (int i = 1; i <= ne; i++) begin
            int exp_bit = (i * me) / ne - ((i - 1) * me) / ne;
            check(step_sel_o == exp_bit[0], {"R3 ", tag}, int'(step_sel_o), exp_bit);
            check(frame_start_o == (i == 1), {"R9 ", tag}, int'(frame_start_o), int'(i == 1));
            if (step_sel_o) begin
                ones++;
                if (first_pos < 0) first_pos = i;
                if (prev_pos >= 0) begin
                    if (i - prev_pos < gmin) gmin = i - prev_pos;
                    if (i - prev_pos > gmax) gmax = i - prev_pos;
                end
                prev_pos = i;
            end
            @(negedge clk);
        end
        check(frame_start_o == 1'b1, {"R9 next ", tag}, int'(frame_start_o), 1);
        check(ones == me, {"R2 ", tag}, ones, me);
        if (me >= 1) begin
            int wrap = ne - prev_pos + first_pos;
            if (wrap < gmin) gmin = wrap;
            if (wrap > gmax) gmax = wrap;
            check(gmax - gmin <= 1, {"R4 ", tag}, gmax - gmin, 1);
        end
    endtask

    task automatic run_pattern(input int n, input int m, input string tag);
        int ne = (n == 0) ? 1 : n;
        int me = (m > ne) ? ne : m;
        period_len = W'(n);
        ones_cnt   = W'(m);
        @(negedge clk);
        wait_frame();
        @(negedge clk);
        wait_frame();
        check_period(ne, me, tag);
    endtask

    task automatic test_reset();
        rst = 1'b1;
        period_len = W'(10);
        ones_cnt   = W'(10);
        repeat (3) begin
            @(negedge clk);
            check(step_sel_o == 1'b0, "R1 sel in reset", int'(step_sel_o), 0);
            check(frame_start_o == 1'b0, "R1 frame in reset", int'(frame_start_o), 0);
        end
        rst = 1'b0;
        @(negedge clk);
        check(step_sel_o == 1'b0, "R1 sel after reset", int'(step_sel_o), 0);
        check(frame_start_o == 1'b0, "R1 frame after reset", int'(frame_start_o), 0);
    endtask

    // R8: a change inside a period leaves that period untouched
    task automatic test_mid_change();
        int ones = 0;
        period_len = W'(12);
        ones_cnt   = W'(5);
        @(negedge clk);
        wait_frame();
        @(negedge clk);
        wait_frame();
        for (int i = 1; i <= 12; i++) begin
            if (i == 4) begin
                period_len = W'(6);
                ones_cnt   = W'(11);
            end
            if (step_sel_o) ones++;
            check(frame_start_o == (i == 1), "R8 frame held", int'(frame_start_o), int'(i == 1));
            @(negedge clk);
        end
        check(ones == 5, "R8 old count kept", ones, 5);
        check_period(6, 6, "R8 new settings");
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        test_reset();
        run_pattern(10, 3, "R2 n10 m3");
        run_pattern(10, 7, "R3 n10 m7");
        run_pattern(16, 5, "R4 n16 m5");
        run_pattern(255, 128, "R4 n255 m128");
        run_pattern(13, 1, "R4 n13 m1");
        run_pattern(7, 0, "R5 zero");
        run_pattern(7, 7, "R5 full");
        run_pattern(5, 9, "R6 clamp");
        run_pattern(0, 0, "R7 n0 m0");
        run_pattern(0, 1, "R7 n0 m1");
        test_mid_change();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule